// File: doc/BRIEF.md
# Byte Update Sequencer with One-Time Protection

This block updates one byte of a 256-byte nonvolatile-style store, held here as a register array, and manages a 32-bit write-once protection vector that guards the lowest 32 addresses. A request is a one-cycle start strobe carrying an operation kind (main update or protection write), an address and a data byte. On the next interface clock pulse (a one-cycle tick input), the block compares the new byte with the stored one. It then decides which programming phases are really needed: an erase phase that raises bits to one, a write phase that lowers bits to zero, both, or neither.

While the chosen phases run, a busy output stays high for a fixed number of ticks that depends on which phases were kept. The store changes only on the tick that ends the last phase. A request that is not allowed (a guarded byte, a mismatched or repeated protection write, or a protection write outside the guarded range) raises an error flag instead, leaves busy low and touches nothing. A combinational read port shows any byte and its protection bit at all times.

Top module: `byte_update_seq`

## Requirements
- R1: After reset every byte reads 0xFF, every protection bit reads 0, and busy and errFlag are low.
- R2: A main update (opProt=0) computes eraseNeed = any bit that is 0 in the old byte and 1 in the new byte. It computes writeNeed = any bit that is 1 in the base and 0 in the new byte, where the base is 0xFF after an erase and the old byte otherwise. The stored result is base AND new, which equals the new byte.
- R3: Once busy has risen, it stays high for exactly L further ticks and falls on the L-th of them. L is 255 when both phases are needed, 124 when exactly one is needed, and 1 when neither is needed.
- R4: Busy rises on the first tick after an accepted strobe. A byte or protection bit changes only on the clock edge where busy falls.
- R5: A protection write (opProt=1) is accepted only for an address below 32 whose bit is clear and whose stored byte equals the supplied byte. It runs for L=124 ticks and then sets the bit at the same index. A set bit never returns to 0.
- R6: A refused request raises errFlag on the first tick after the strobe and keeps busy low, with no change to any byte or protection bit. There are four refused cases: a main update to an address below 32 whose bit is set, and a protection write with mismatched data, with an already set bit, or with an address of 32 or more. errFlag stays high until the next accepted strobe clears it.
- R7: A start strobe that arrives while a request is waiting for its first tick or while busy is high is ignored.
- R8: rdData shows the byte at rdAddr combinationally. rdProt shows its protection bit, and reads 0 for addresses of 32 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | One-cycle request strobe |
| opProt | input | 1 | 0 = main update, 1 = protection write |
| addrIn | input | 8 | Request address |
| dataIn | input | 8 | Request data byte |
| pulseTick | input | 1 | One-cycle interface clock pulse |
| rdAddr | input | 8 | Read port address |
| busy | output | 1 | High while programming phases run |
| errFlag | output | 1 | Last request was refused |
| rdData | output | 8 | Byte at rdAddr |
| rdProt | output | 1 | Protection bit of rdAddr |

## Verification
The error decision and the rise of busy are both due on the clock edge of the first tick after the strobe. The stored byte, the protection bit and the fall of busy are all due together on the edge of the L-th tick after that rise, where L is 255, 124 or 1. The bench's reference model advances on the same clock edges, keyed on the same tick. It is compared one nanosecond after every rising edge, so every busy, error, byte and protection value is checked on the exact cycle it is due. Per-request checks also count the ticks seen while busy is high and compare that count with the length that the old and new bytes call for.

// File: rtl/upd_pkg.sv
package upd_pkg;
  typedef enum logic {OP_MAIN = 1'b0, OP_PROT = 1'b1} opKind_e;

  typedef struct packed {
    logic latchReq;
    logic commit;
  } ctrlStrb_t;
endpackage

// File: rtl/upd_datapath.sv
module upd_datapath
  import upd_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int PROT_SPAN     = 32,
  parameter int SINGLE_PULSES = 124,
  parameter int DUAL_PULSES   = 255,
  parameter int NOOP_PULSES   = 1,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PROT_W = $clog2(PROT_SPAN),
  localparam int CNT_W  = $clog2(DUAL_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  opKind_e           opIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdProt,
  output logic              refused,
  output logic [CNT_W-1:0]  phaseLen
);
  logic [DATA_W-1:0]    memArr [DEPTH];
  logic [PROT_SPAN-1:0] protBits;
  logic [ADDR_W-1:0]    reqAddr;
  logic [DATA_W-1:0]    reqData;
  opKind_e              reqOp;

  logic [DATA_W-1:0] oldByte, baseByte, newByte;
  logic inSpan, protHit, eraseNeed, writeNeed;

  always_comb begin
    oldByte   = memArr[reqAddr];
    inSpan    = (int'(reqAddr) < PROT_SPAN);
    protHit   = inSpan && protBits[reqAddr[PROT_W-1:0]];
    eraseNeed = |(~oldByte & reqData);
    baseByte  = eraseNeed ? '1 : oldByte;
    writeNeed = |(baseByte & ~reqData);
    newByte   = baseByte & reqData;
  end

  always_comb begin
    if (reqOp == OP_PROT) begin
      refused  = !inSpan || protHit || (oldByte != reqData);
      phaseLen = CNT_W'(SINGLE_PULSES);
    end else begin
      refused = protHit;
      case ({eraseNeed, writeNeed})
        2'b11:        phaseLen = CNT_W'(DUAL_PULSES);
        2'b10, 2'b01: phaseLen = CNT_W'(SINGLE_PULSES);
        default:      phaseLen = CNT_W'(NOOP_PULSES);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr <= '0;
      reqData <= '0;
      reqOp   <= OP_MAIN;
    end else if (strb.latchReq) begin
      reqAddr <= addrIn;
      reqData <= dataIn;
      reqOp   <= opIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
      protBits <= '0;
    end else if (strb.commit) begin
      if (reqOp == OP_MAIN) memArr[reqAddr] <= newByte;
      else protBits[reqAddr[PROT_W-1:0]] <= 1'b1;
    end
  end

  always_comb begin
    rdData = memArr[rdAddr];
    rdProt = (int'(rdAddr) < PROT_SPAN) ? protBits[rdAddr[PROT_W-1:0]] : 1'b0;
  end
endmodule

// File: rtl/upd_control.sv
module upd_control
  import upd_pkg::*;
#(
  parameter int DUAL_PULSES = 255,
  localparam int CNT_W = $clog2(DUAL_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             pulseTick,
  input  logic             refused,
  input  logic [CNT_W-1:0] phaseLen,
  output ctrlStrb_t        strb,
  output logic             busy,
  output logic             errFlag
);
  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN} state_e;
  state_e            state;
  logic [CNT_W-1:0]  left;

  always_comb begin
    strb.latchReq = (state == S_IDLE) && startStb;
    strb.commit   = (state == S_RUN) && pulseTick && (left == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      left    <= '0;
      busy    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startStb) begin
          state   <= S_ARMED;
          errFlag <= 1'b0;
        end
        S_ARMED: if (pulseTick) begin
          if (refused) begin
            errFlag <= 1'b1;
            state   <= S_IDLE;
          end else begin
            busy  <= 1'b1;
            left  <= phaseLen;
            state <= S_RUN;
          end
        end
        S_RUN: if (pulseTick) begin
          if (left == CNT_W'(1)) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            left <= left - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/byte_update_seq.sv
module byte_update_seq
  import upd_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int PROT_SPAN     = 32,
  parameter int SINGLE_PULSES = 124,
  parameter int DUAL_PULSES   = 255,
  parameter int NOOP_PULSES   = 1,
  localparam int CNT_W = $clog2(DUAL_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              opProt,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              pulseTick,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              busy,
  output logic              errFlag,
  output logic [DATA_W-1:0] rdData,
  output logic              rdProt
);
  ctrlStrb_t        strb;
  logic             refused;
  logic [CNT_W-1:0] phaseLen;

  upd_control #(.DUAL_PULSES(DUAL_PULSES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .pulseTick(pulseTick),
    .refused(refused), .phaseLen(phaseLen), .strb(strb),
    .busy(busy), .errFlag(errFlag)
  );

  upd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_SPAN(PROT_SPAN),
    .SINGLE_PULSES(SINGLE_PULSES), .DUAL_PULSES(DUAL_PULSES),
    .NOOP_PULSES(NOOP_PULSES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opIn(opKind_e'(opProt)),
    .addrIn(addrIn), .dataIn(dataIn), .rdAddr(rdAddr),
    .rdData(rdData), .rdProt(rdProt), .refused(refused), .phaseLen(phaseLen)
  );
endmodule

// File: rtl/upd_checker.sv
module upd_checker #(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int SINGLE_PULSES = 124,
  parameter int DUAL_PULSES   = 255,
  parameter int NOOP_PULSES   = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              pulseTick,
  input logic              busy,
  input logic              errFlag,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              rdProt
);
  int busyTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyTicks <= 0;
    else if (!busy) busyTicks <= 0;
    else if (pulseTick) busyTicks <= busyTicks + 1;
  end

  // R3: busy length is one of the three allowed phase totals
  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyTicks) == DUAL_PULSES - 1 ||
                     $past(busyTicks) == SINGLE_PULSES - 1 ||
                     $past(busyTicks) == NOOP_PULSES - 1));

  // R4: busy edges land only on ticks
  assert_busy_rise_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(pulseTick));
  assert_busy_fall_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(pulseTick));

  // R4: a stored byte moves only where busy falls
  assert_data_only_at_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdAddr) && !$fell(busy)) |-> $stable(rdData));

  // R5: a protection bit never clears
  assert_prot_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdAddr) && $past(rdProt)) |-> rdProt);

  // R6: error appears on a tick and never alongside busy
  assert_err_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ($past(pulseTick) && !$past(busy)));
  assert_err_busy_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && errFlag));
endmodule

bind byte_update_seq upd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SINGLE_PULSES(SINGLE_PULSES),
  .DUAL_PULSES(DUAL_PULSES), .NOOP_PULSES(NOOP_PULSES)
) u_chk (
  .clk(clk), .rstN(rstN), .pulseTick(pulseTick), .busy(busy),
  .errFlag(errFlag), .rdAddr(rdAddr), .rdData(rdData), .rdProt(rdProt)
);

// File: tb/byte_update_seq_tb.sv
`timescale 1ns/1ps
module byte_update_seq_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic startStb = 1'b0, opProt = 1'b0, pulseTick = 1'b0;
  logic [7:0] addrIn = '0, dataIn = '0, rdAddr = '0;
  logic busy, errFlag, rdProt;
  logic [7:0] rdData;

  int vectors = 0, fails = 0, cycles = 0, busyTicks = 0;
  bit tickPhase = 1'b0, done = 1'b0;

  // reference model state
  logic [7:0] mMem [256];
  bit   mProt [32];
  int   mPhase = 0, mLeft = 0;
  bit   expBusy = 0, expErr = 0, mOp = 0;
  logic [7:0] mAddr = '0, mData = '0;

  always #2.5 clk = ~clk;

  byte_update_seq u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .opProt(opProt),
    .addrIn(addrIn), .dataIn(dataIn), .pulseTick(pulseTick), .rdAddr(rdAddr),
    .busy(busy), .errFlag(errFlag), .rdData(rdData), .rdProt(rdProt)
  );

  // tick on every second cycle, driven away from the active edge
  always @(negedge clk) begin
    tickPhase <= ~tickPhase;
    pulseTick <= tickPhase;
  end

  function automatic int lenFor(logic [7:0] oldB, logic [7:0] newB);
    bit e, w;
    e = ((~oldB & newB) != 8'h00);
    w = (((e ? 8'hFF : oldB) & ~newB) != 8'h00);
    if (e && w) return 255;
    if (e || w) return 124;
    return 1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (pulseTick && busy) busyTicks++;
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mMem[i] = 8'hFF;
      for (int i = 0; i < 32; i++) mProt[i] = 1'b0;
      mPhase = 0; expBusy = 0; expErr = 0;
    end else begin
      case (mPhase)
        0: if (startStb) begin
          mOp = opProt; mAddr = addrIn; mData = dataIn;
          expErr = 0; mPhase = 1;
        end
        1: if (pulseTick) begin
          bit bad;
          if (mOp) bad = (mAddr >= 32) || mProt[mAddr[4:0]] || (mMem[mAddr] != mData);
          else     bad = (mAddr < 32) && mProt[mAddr[4:0]];
          if (bad) begin expErr = 1; mPhase = 0; end
          else begin
            expBusy = 1; mPhase = 2;
            mLeft = mOp ? 124 : lenFor(mMem[mAddr], mData);
          end
        end
        default: if (pulseTick) begin
          if (mLeft == 1) begin
            if (mOp) mProt[mAddr[4:0]] = 1'b1; else mMem[mAddr] = mData;
            expBusy = 0; mPhase = 0;
          end else mLeft--;
        end
      endcase
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      vectors++;
      if (busy !== expBusy) begin fails++;
        $display("FAIL R3 busy: actual %0b expected %0b at cycle %0d", busy, expBusy, cycles); end
      if (errFlag !== expErr) begin fails++;
        $display("FAIL R6 errFlag: actual %0b expected %0b at cycle %0d", errFlag, expErr, cycles); end
      if (rdData !== mMem[rdAddr]) begin fails++;
        $display("FAIL R4 rdData: actual %02h expected %02h at cycle %0d", rdData, mMem[rdAddr], cycles); end
      if (rdProt !== ((rdAddr < 32) ? mProt[rdAddr[4:0]] : 1'b0)) begin fails++;
        $display("FAIL R8 rdProt: actual %0b at cycle %0d", rdProt, cycles); end
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReq(bit op, logic [7:0] a, logic [7:0] d, int expLen, bit expE,
                       logic [7:0] expData, bit expP, string tag);
    @(negedge clk);
    rdAddr = a; opProt = op; addrIn = a; dataIn = d; startStb = 1'b1; busyTicks = 0;
    @(negedge clk);
    startStb = 1'b0;
    while (mPhase != 0) @(negedge clk);
    @(negedge clk);
    check({tag, " length"}, busyTicks, expLen);
    check({tag, " error"}, int'(errFlag), int'(expE));
    check({tag, " byte"}, int'(rdData), int'(expData));
    check({tag, " prot"}, int'(rdProt), int'(expP));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    rdAddr = 8'd40;
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(errFlag), 0);
    check("R1 byte", int'(rdData), 8'hFF);
    rdAddr = 8'd3; #0.1;
    check("R1 prot", int'(rdProt), 0);
    // R2/R3: phase selection
    doReq(0, 8'd40, 8'h5A, 124, 0, 8'h5A, 0, "R2 write-only");
    doReq(0, 8'd40, 8'h5A, 1,   0, 8'h5A, 0, "R3 no-phase");
    doReq(0, 8'd40, 8'hA5, 255, 0, 8'hA5, 0, "R3 erase+write");
    doReq(0, 8'd40, 8'hFF, 124, 0, 8'hFF, 0, "R2 erase-only");
    doReq(0, 8'd5,  8'h3C, 124, 0, 8'h3C, 0, "R4 low address update");
    // R5/R6: protection
    doReq(1, 8'd5,  8'h3D, 0, 1, 8'h3C, 0, "R6 prot mismatch");
    doReq(1, 8'd5,  8'h3C, 124, 0, 8'h3C, 1, "R5 prot set");
    doReq(0, 8'd5,  8'h00, 0, 1, 8'h3C, 1, "R6 guarded update");
    doReq(1, 8'd5,  8'h3C, 0, 1, 8'h3C, 1, "R6 prot repeat");
    doReq(1, 8'd40, 8'hFF, 0, 1, 8'hFF, 0, "R6 prot out of range");
    doReq(0, 8'd6,  8'h00, 124, 0, 8'h00, 0, "R6 error cleared, R8 neighbour");
    doReq(0, 8'd32, 8'h0F, 124, 0, 8'h0F, 0, "R8 address 32 unguarded");
    // R7: strobe during busy ignored
    @(negedge clk);
    rdAddr = 8'd41; opProt = 0; addrIn = 8'd40; dataIn = 8'h00; startStb = 1'b1;
    @(negedge clk); startStb = 1'b0;
    repeat (20) @(negedge clk);
    addrIn = 8'd41; dataIn = 8'h11; startStb = 1'b1;
    @(negedge clk); startStb = 1'b0;
    while (mPhase != 0 || busy) @(negedge clk);
    @(negedge clk);
    check("R7 ignored strobe byte", int'(rdData), 8'hFF);
    rdAddr = 8'd40; #0.1;
    check("R7 first request byte", int'(rdData), 8'h00);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule